// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block is the controller half of AC97 codec register traffic. A host programs it through a small word-addressed register window. Writing the command address register arms a single codec command. The engine places that command on the outgoing command slots of the next link frame in which the link is running. Status slots returned by the codec are captured into the same address and data registers. Sticky flags report each slot that goes out and each slot that comes in, and software clears them by writing zeros.

Serial bit framing is not part of the block. An outside framer gives a one-cycle strobe at the start of each outgoing frame, so the block can present tag bits and slot words for that frame. It gives another strobe when an incoming frame has been parsed, together with the valid tags and the extracted status fields. The control register drives the codec cold-reset and warm-reset lines and gates the link. An audio control register holds sample-width selections and the slot-12 enable. One interrupt line combines the status flags with their enables.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: After reset every mapped register reads 0. All transmit tags and slot words are 0, irq_o is 0, codec_rst_n_o is 1 and warm_rst_o is 0.
- R2: Control register at offset 0x08. Bits 11 (cold reset), 10 (warm reset), 9 and 5 (link start) are read/write. Bit 15 is read-only and shows codec_rdy_i one clock late. All other bits read 0. codec_rst_n_o is the inverse of bit 11 and warm_rst_o equals bit 10.
- R3: A write to offset 0x20 with bit 19 clear arms a write command using index bits 18:12 and the current 16-bit value held in bits 19:4 of offset 0x24. At the next frame strobe with the link running (bit 5 set, bits 11 and 10 clear), tx_slot1_o = {0, index, 12'b0} and tx_slot2_o = {value, 4'b0}, and both the address tag and the data tag are 1.
- R4: A write to offset 0x20 with bit 19 set arms a read command. Its frame carries tx_slot1_o = {1, index, 12'b0} with the address tag 1, while the data tag is 0 and tx_slot2_o is 0.
- R5: One write to offset 0x20 produces exactly one command frame. Later frames carry no command tags and zero slots until 0x20 is written again. Writes to any other offset arm nothing.
- R6: While the link is not running, an armed command is held. Frames go out with no command tags and no transmit flags set. The command is sent at the first frame strobe after the link runs.
- R7: Transmit status at offset 0x54. Bit 31 sets when a command address slot is sent and bit 30 when a data slot is sent. A host write keeps a set bit where the written bit is 1 and clears it where the written bit is 0. A new set wins over a clear in the same cycle.
- R8: On rx_frame_i, when the address tag is valid, rx_sts_idx_i is loaded into bits 18:12 of offset 0x20 and bit 22 of offset 0x5C sets. When the data tag is valid, rx_sts_val_i is loaded into bits 19:4 of offset 0x24 and bit 21 of 0x5C sets. Fields with invalid tags change nothing.
- R9: Bits 22 and 21 of offset 0x5C are sticky and are cleared by writing 0 to them. Writing 1 keeps them.
- R10: Audio control at offset 0x60. Bits 30, 29, 26, 24, 23, 22 and 21 are read/write and the rest read 0. At each frame strobe, the slot-12 tag output is set to bit 26 ANDed with link running.
- R11: Interrupt enables at 0x50 (bits 31 and 30) and 0x58 (bits 22 and 21) are read/write and their other bits read 0. irq_o is 1 exactly when some status flag and its matching enable bit are both set.
- R12: Unmapped offsets, including the PCM words at 0x28 and 0x2C, read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 8 | Host byte offset |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for reg_addr_i (combinational) |
| frame_i | input | 1 | Start-of-outgoing-frame strobe |
| codec_rdy_i | input | 1 | Codec ready indication from the link |
| rx_frame_i | input | 1 | Incoming frame parsed strobe |
| rx_adr_vld_i | input | 1 | Incoming status address tag valid |
| rx_dat_vld_i | input | 1 | Incoming status data tag valid |
| rx_sts_idx_i | input | 7 | Received status register index |
| rx_sts_val_i | input | 16 | Received status register value |
| tx_tag_adr_o | output | 1 | Outgoing command address slot valid |
| tx_tag_dat_o | output | 1 | Outgoing command data slot valid |
| tx_tag_s12_o | output | 1 | Outgoing slot 12 valid |
| tx_slot1_o | output | 20 | Outgoing command address slot word |
| tx_slot2_o | output | 20 | Outgoing command data slot word |
| codec_rst_n_o | output | 1 | Codec cold reset, active low |
| warm_rst_o | output | 1 | Codec warm reset request |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench goes after the single-shot rule. A controller that failed to drop its pending command would repeat the command in the frame after it was sent, and one that armed on a data-register write would send a stray frame. It checks that a read command leaves the data slot untagged and zero; an engine that always sent both slots would put a stale write on the codec. It holds a command across a cold reset to show that it is neither lost nor sent early. It clears the sticky flags one bit at a time, so a write that wiped the whole register or ignored zeros would be caught. It also feeds received frames with invalid tags and nonzero fields, which catches a capture path that ignores the tags.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int BUS_W   = 32;
  localparam int OFS_W   = 8;
  localparam int SLOT_W  = 20;
  localparam int IDX_W   = 7;
  localparam int VAL_W   = 16;
  localparam int IDX_LSB = 12;
  localparam int VAL_LSB = 4;
  localparam int RD_BIT  = IDX_LSB + IDX_W;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CADR  = 8'h20;
  localparam logic [OFS_W-1:0] OFS_CDAT  = 8'h24;
  localparam logic [OFS_W-1:0] OFS_TIEN  = 8'h50;
  localparam logic [OFS_W-1:0] OFS_TSTAT = 8'h54;
  localparam logic [OFS_W-1:0] OFS_RIEN  = 8'h58;
  localparam logic [OFS_W-1:0] OFS_RSTAT = 8'h5C;
  localparam logic [OFS_W-1:0] OFS_ACTL  = 8'h60;

  localparam int CTRL_RDY   = 15;
  localparam int CTRL_COLD  = 11;
  localparam int CTRL_WARM  = 10;
  localparam int CTRL_START = 5;
  localparam logic [BUS_W-1:0] CTRL_WMASK = 32'h0000_0E20;

  localparam int TST_ADR = 31;
  localparam int TST_DAT = 30;
  localparam int RST_ADR = 22;
  localparam int RST_DAT = 21;
  localparam logic [BUS_W-1:0] TST_MASK = 32'hC000_0000;
  localparam logic [BUS_W-1:0] RST_MASK = 32'h0060_0000;

  localparam int ACTL_S12 = 26;
  localparam logic [BUS_W-1:0] ACTL_MASK = 32'h65E0_0000;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } cmd_t;
endpackage

// File: rtl/acc_tx_slots.sv
module acc_tx_slots
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  cmd_t              arm_cmd_i,
  input  logic              frame_i,
  input  logic              link_run_i,
  input  logic              s12_en_i,
  output logic              tag_adr_o,
  output logic              tag_dat_o,
  output logic              tag_s12_o,
  output logic [SLOT_W-1:0] slot1_o,
  output logic [SLOT_W-1:0] slot2_o,
  output logic              sent_adr_o,
  output logic              sent_dat_o
);
  logic              pend_q, pend_d;
  cmd_t              cmd_q, cmd_d;
  logic              tag_adr_q, tag_adr_d;
  logic              tag_dat_q, tag_dat_d;
  logic              tag_s12_q, tag_s12_d;
  logic [SLOT_W-1:0] slot1_q, slot1_d;
  logic [SLOT_W-1:0] slot2_q, slot2_d;
  logic              send;

  assign send       = frame_i & link_run_i & pend_q;
  assign sent_adr_o = send;
  assign sent_dat_o = send & ~cmd_q.rd;

  always_comb begin
    pend_d    = pend_q;
    cmd_d     = cmd_q;
    tag_adr_d = tag_adr_q;
    tag_dat_d = tag_dat_q;
    tag_s12_d = tag_s12_q;
    slot1_d   = slot1_q;
    slot2_d   = slot2_q;
    if (frame_i) begin
      tag_adr_d = send;
      tag_dat_d = send & ~cmd_q.rd;
      tag_s12_d = link_run_i & s12_en_i;
      slot1_d   = send ? {cmd_q.rd, cmd_q.idx, {IDX_LSB{1'b0}}} : '0;
      slot2_d   = (send & ~cmd_q.rd) ? {cmd_q.val, {VAL_LSB{1'b0}}} : '0;
    end
    if (send) pend_d = 1'b0;
    if (arm_i) begin
      pend_d = 1'b1;
      cmd_d  = arm_cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      cmd_q     <= '0;
      tag_adr_q <= 1'b0;
      tag_dat_q <= 1'b0;
      tag_s12_q <= 1'b0;
      slot1_q   <= '0;
      slot2_q   <= '0;
    end else begin
      pend_q    <= pend_d;
      cmd_q     <= cmd_d;
      tag_adr_q <= tag_adr_d;
      tag_dat_q <= tag_dat_d;
      tag_s12_q <= tag_s12_d;
      slot1_q   <= slot1_d;
      slot2_q   <= slot2_d;
    end
  end

  assign tag_adr_o = tag_adr_q;
  assign tag_dat_o = tag_dat_q;
  assign tag_s12_o = tag_s12_q;
  assign slot1_o   = slot1_q;
  assign slot2_o   = slot2_q;

  // R5
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !pend_q) |=> !tag_adr_q);

  // R4
  read_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_adr_q && slot1_q[RD_BIT]) |-> (!tag_dat_q && slot2_q == '0));
endmodule

// File: rtl/acc_rx_status.sv
module acc_rx_status
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_adr_i,
  input  logic             wr_dat_i,
  input  logic             wr_rd_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic             rx_frame_i,
  input  logic             rx_adr_vld_i,
  input  logic             rx_dat_vld_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [VAL_W-1:0] rx_val_i,
  output logic             rd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VAL_W-1:0] val_o,
  output logic             got_adr_o,
  output logic             got_dat_o
);
  logic             rd_q, rd_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VAL_W-1:0] val_q, val_d;

  assign got_adr_o = rx_frame_i & rx_adr_vld_i;
  assign got_dat_o = rx_frame_i & rx_dat_vld_i;

  always_comb begin
    rd_d  = rd_q;
    idx_d = idx_q;
    val_d = val_q;
    if (got_adr_o) idx_d = rx_idx_i;
    if (got_dat_o) val_d = rx_val_i;
    if (wr_adr_i) begin
      rd_d  = wr_rd_i;
      idx_d = wr_idx_i;
    end
    if (wr_dat_i) val_d = wr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      idx_q <= '0;
      val_q <= '0;
    end else begin
      rd_q  <= rd_d;
      idx_q <= idx_d;
      val_q <= val_d;
    end
  end

  assign rd_o  = rd_q;
  assign idx_o = idx_q;
  assign val_o = val_q;

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_frame_i && rx_adr_vld_i) && !wr_adr_i) |=> $stable(idx_q));

  // R8
  val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_frame_i && rx_dat_vld_i) && !wr_dat_i) |=> $stable(val_q));
endmodule

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl
  import acc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we_i,
  input  logic [OFS_W-1:0]      reg_addr_i,
  input  logic [BUS_W-1:0]      reg_wdata_i,
  output logic [BUS_W-1:0]      reg_rdata_o,
  input  logic                  frame_i,
  input  logic                  codec_rdy_i,
  input  logic                  rx_frame_i,
  input  logic                  rx_adr_vld_i,
  input  logic                  rx_dat_vld_i,
  input  logic [IDX_W-1:0]      rx_sts_idx_i,
  input  logic [VAL_W-1:0]      rx_sts_val_i,
  output logic                  tx_tag_adr_o,
  output logic                  tx_tag_dat_o,
  output logic                  tx_tag_s12_o,
  output logic [SLOT_W-1:0]     tx_slot1_o,
  output logic [SLOT_W-1:0]     tx_slot2_o,
  output logic                  codec_rst_n_o,
  output logic                  warm_rst_o,
  output logic                  irq_o
);
  localparam int PAD_ADR = BUS_W - RD_BIT - 1;
  localparam int PAD_DAT = BUS_W - VAL_W - VAL_LSB;

  logic [BUS_W-1:0] ctrl_q, ctrl_d;
  logic [BUS_W-1:0] tien_q, tien_d;
  logic [BUS_W-1:0] rien_q, rien_d;
  logic [BUS_W-1:0] tst_q, tst_d;
  logic [BUS_W-1:0] rst_q, rst_d;
  logic [BUS_W-1:0] actl_q, actl_d;
  logic             rdy_q;

  logic             wr_ctrl, wr_cadr, wr_cdat, wr_tien, wr_tst, wr_rien, wr_rst, wr_actl;
  logic             link_run;
  logic             sent_adr, sent_dat, got_adr, got_dat;
  logic             sts_rd;
  logic [IDX_W-1:0] sts_idx;
  logic [VAL_W-1:0] sts_val;
  cmd_t             arm_cmd;

  assign wr_ctrl = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign wr_cadr = reg_we_i && (reg_addr_i == OFS_CADR);
  assign wr_cdat = reg_we_i && (reg_addr_i == OFS_CDAT);
  assign wr_tien = reg_we_i && (reg_addr_i == OFS_TIEN);
  assign wr_tst  = reg_we_i && (reg_addr_i == OFS_TSTAT);
  assign wr_rien = reg_we_i && (reg_addr_i == OFS_RIEN);
  assign wr_rst  = reg_we_i && (reg_addr_i == OFS_RSTAT);
  assign wr_actl = reg_we_i && (reg_addr_i == OFS_ACTL);

  assign link_run = ctrl_q[CTRL_START] & ~ctrl_q[CTRL_COLD] & ~ctrl_q[CTRL_WARM];

  assign arm_cmd.rd  = reg_wdata_i[RD_BIT];
  assign arm_cmd.idx = reg_wdata_i[IDX_LSB +: IDX_W];
  assign arm_cmd.val = sts_val;

  acc_tx_slots u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (wr_cadr),
    .arm_cmd_i  (arm_cmd),
    .frame_i    (frame_i),
    .link_run_i (link_run),
    .s12_en_i   (actl_q[ACTL_S12]),
    .tag_adr_o  (tx_tag_adr_o),
    .tag_dat_o  (tx_tag_dat_o),
    .tag_s12_o  (tx_tag_s12_o),
    .slot1_o    (tx_slot1_o),
    .slot2_o    (tx_slot2_o),
    .sent_adr_o (sent_adr),
    .sent_dat_o (sent_dat)
  );

  acc_rx_status u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_adr_i     (wr_cadr),
    .wr_dat_i     (wr_cdat),
    .wr_rd_i      (reg_wdata_i[RD_BIT]),
    .wr_idx_i     (reg_wdata_i[IDX_LSB +: IDX_W]),
    .wr_val_i     (reg_wdata_i[VAL_LSB +: VAL_W]),
    .rx_frame_i   (rx_frame_i),
    .rx_adr_vld_i (rx_adr_vld_i),
    .rx_dat_vld_i (rx_dat_vld_i),
    .rx_idx_i     (rx_sts_idx_i),
    .rx_val_i     (rx_sts_val_i),
    .rd_o         (sts_rd),
    .idx_o        (sts_idx),
    .val_o        (sts_val),
    .got_adr_o    (got_adr),
    .got_dat_o    (got_dat)
  );

  always_comb begin
    ctrl_d = wr_ctrl ? (reg_wdata_i & CTRL_WMASK) : ctrl_q;
    tien_d = wr_tien ? (reg_wdata_i & TST_MASK)   : tien_q;
    rien_d = wr_rien ? (reg_wdata_i & RST_MASK)   : rien_q;
    actl_d = wr_actl ? (reg_wdata_i & ACTL_MASK)  : actl_q;
    tst_d  = wr_tst  ? (tst_q & reg_wdata_i)      : tst_q;
    rst_d  = wr_rst  ? (rst_q & reg_wdata_i)      : rst_q;
    if (sent_adr) tst_d[TST_ADR] = 1'b1;
    if (sent_dat) tst_d[TST_DAT] = 1'b1;
    if (got_adr)  rst_d[RST_ADR] = 1'b1;
    if (got_dat)  rst_d[RST_DAT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tien_q <= '0;
      rien_q <= '0;
      actl_q <= '0;
      tst_q  <= '0;
      rst_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tien_q <= tien_d;
      rien_q <= rien_d;
      actl_q <= actl_d;
      tst_q  <= tst_d;
      rst_q  <= rst_d;
      rdy_q  <= codec_rdy_i;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL: begin
        reg_rdata_o           = ctrl_q;
        reg_rdata_o[CTRL_RDY] = rdy_q;
      end
      OFS_CADR:  reg_rdata_o = {{PAD_ADR{1'b0}}, sts_rd, sts_idx, {IDX_LSB{1'b0}}};
      OFS_CDAT:  reg_rdata_o = {{PAD_DAT{1'b0}}, sts_val, {VAL_LSB{1'b0}}};
      OFS_TIEN:  reg_rdata_o = tien_q;
      OFS_TSTAT: reg_rdata_o = tst_q;
      OFS_RIEN:  reg_rdata_o = rien_q;
      OFS_RSTAT: reg_rdata_o = rst_q;
      OFS_ACTL:  reg_rdata_o = actl_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign codec_rst_n_o = ~ctrl_q[CTRL_COLD];
  assign warm_rst_o    = ctrl_q[CTRL_WARM];
  assign irq_o         = (|(tst_q & tien_q)) | (|(rst_q & rien_q));

  // R7
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_q[TST_ADR] && !wr_tst) |=> tst_q[TST_ADR]);

  // R9
  rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q[RST_ADR] && !wr_rst) |=> rst_q[RST_ADR]);

  // R6
  cold_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && ctrl_q[CTRL_COLD]) |=> (!tx_tag_adr_o && !tx_tag_dat_o));

  // R7
  tx_flag_with_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_tag_adr_o) |-> tst_q[TST_ADR]);
endmodule

// File: tb/sim_ac97_cmd_ctrl.sv
module sim_ac97_cmd_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_we_i;
  logic [7:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        frame_i;
  logic        codec_rdy_i;
  logic        rx_frame_i;
  logic        rx_adr_vld_i;
  logic        rx_dat_vld_i;
  logic [6:0]  rx_sts_idx_i;
  logic [15:0] rx_sts_val_i;
  logic        tx_tag_adr_o;
  logic        tx_tag_dat_o;
  logic        tx_tag_s12_o;
  logic [19:0] tx_slot1_o;
  logic [19:0] tx_slot2_o;
  logic        codec_rst_n_o;
  logic        warm_rst_o;
  logic        irq_o;

  int n_chk;
  int n_bad;
  bit done;

  ac97_cmd_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
  endtask

  task automatic rx(input logic v1, input logic v2, input logic [6:0] idx, input logic [15:0] val);
    @(negedge clk);
    rx_frame_i = 1'b1; rx_adr_vld_i = v1; rx_dat_vld_i = v2;
    rx_sts_idx_i = idx; rx_sts_val_i = val;
    @(negedge clk);
    rx_frame_i = 1'b0; rx_adr_vld_i = 1'b0; rx_dat_vld_i = 1'b0;
  endtask

  task automatic chk_tx(input string req, input logic a, input logic d,
                        input logic [19:0] s1, input logic [19:0] s2);
    chk({req, " adr tag"}, {31'd0, tx_tag_adr_o}, {31'd0, a});
    chk({req, " dat tag"}, {31'd0, tx_tag_dat_o}, {31'd0, d});
    chk({req, " slot1"}, {12'd0, tx_slot1_o}, {12'd0, s1});
    chk({req, " slot2"}, {12'd0, tx_slot2_o}, {12'd0, s2});
  endtask

  task automatic t_reset();
    foreach (u0.u_tx.slot1_q[i]) ; // keep loop-free: no internal reads used below
    rdchk("R1 ctrl", 8'h08, 32'h0);
    rdchk("R1 cadr", 8'h20, 32'h0);
    rdchk("R1 cdat", 8'h24, 32'h0);
    rdchk("R1 tstat", 8'h54, 32'h0);
    rdchk("R1 rstat", 8'h5C, 32'h0);
    rdchk("R1 actl", 8'h60, 32'h0);
    chk_tx("R1", 1'b0, 1'b0, 20'h0, 20'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 rst_n", {31'd0, codec_rst_n_o}, 32'd1);
    chk("R1 warm", {31'd0, warm_rst_o}, 32'd0);
  endtask

  task automatic t_ctrl();
    wr(8'h08, 32'hFFFF_FFFF);
    rdchk("R2 rw bits", 8'h08, 32'h0000_0E20);
    chk("R2 rst_n low", {31'd0, codec_rst_n_o}, 32'd0);
    chk("R2 warm high", {31'd0, warm_rst_o}, 32'd1);
    codec_rdy_i = 1'b1;
    @(negedge clk);
    rdchk("R2 ready bit", 8'h08, 32'h0000_8E20);
    wr(8'h08, 32'h0000_0220);
    rdchk("R2 run", 8'h08, 32'h0000_8220);
    chk("R2 rst_n high", {31'd0, codec_rst_n_o}, 32'd1);
    chk("R2 warm low", {31'd0, warm_rst_o}, 32'd0);
  endtask

  task automatic t_write_cmd();
    wr(8'h24, 32'hFFFF_FFFF);
    rdchk("R3 cdat mask", 8'h24, 32'h000F_FFF0);
    wr(8'h24, 32'h000A_BCD0);
    frame();
    chk_tx("R5 data write arms nothing", 1'b0, 1'b0, 20'h0, 20'h0);
    wr(8'h20, 32'h0002_C000);
    rdchk("R3 cadr readback", 8'h20, 32'h0002_C000);
    frame();
    chk_tx("R3 write frame", 1'b1, 1'b1, 20'h2C000, 20'hABCD0);
    rdchk("R7 both flags", 8'h54, 32'hC000_0000);
    frame();
    chk_tx("R5 next frame empty", 1'b0, 1'b0, 20'h0, 20'h0);
    wr(8'h54, 32'h4000_0000);
    rdchk("R7 partial clear", 8'h54, 32'h4000_0000);
    wr(8'h54, 32'h0);
    rdchk("R7 full clear", 8'h54, 32'h0);
  endtask

  task automatic t_read_cmd();
    wr(8'h20, 32'h000F_C000);
    frame();
    chk_tx("R4 read frame", 1'b1, 1'b0, 20'hFC000, 20'h0);
    rdchk("R4 only addr flag", 8'h54, 32'h8000_0000);
    wr(8'h54, 32'h0);
  endtask

  task automatic t_hold();
    wr(8'h08, 32'h0000_0A20);
    wr(8'h20, 32'h0001_3000);
    frame();
    chk_tx("R6 held in cold reset", 1'b0, 1'b0, 20'h0, 20'h0);
    rdchk("R6 no flags", 8'h54, 32'h0);
    wr(8'h08, 32'h0000_0620);
    frame();
    chk_tx("R6 held in warm reset", 1'b0, 1'b0, 20'h0, 20'h0);
    wr(8'h08, 32'h0000_0220);
    frame();
    chk_tx("R6 sent after run", 1'b1, 1'b1, 20'h13000, 20'hABCD0);
    wr(8'h54, 32'h0);
  endtask

  task automatic t_rx();
    rx(1'b1, 1'b1, 7'h26, 16'h1234);
    rdchk("R8 idx captured", 8'h20, 32'h0002_6000);
    rdchk("R8 val captured", 8'h24, 32'h0001_2340);
    rdchk("R8 flags set", 8'h5C, 32'h0060_0000);
    rx(1'b0, 1'b0, 7'h7F, 16'hFFFF);
    rdchk("R8 invalid idx ignored", 8'h20, 32'h0002_6000);
    rdchk("R8 invalid val ignored", 8'h24, 32'h0001_2340);
    wr(8'h5C, 32'h0020_0000);
    rdchk("R9 partial clear", 8'h5C, 32'h0020_0000);
    rx(1'b0, 1'b1, 7'h00, 16'h0BEE);
    rdchk("R8 data only", 8'h24, 32'h0000_BEE0);
    rdchk("R8 idx kept", 8'h20, 32'h0002_6000);
    rdchk("R9 addr flag stays clear", 8'h5C, 32'h0020_0000);
    wr(8'h5C, 32'h0);
    rdchk("R9 full clear", 8'h5C, 32'h0);
  endtask

  task automatic t_actl();
    wr(8'h60, 32'hFFFF_FFFF);
    rdchk("R10 mask", 8'h60, 32'h65E0_0000);
    frame();
    chk("R10 s12 on", {31'd0, tx_tag_s12_o}, 32'd1);
    wr(8'h08, 32'h0000_0A20);
    frame();
    chk("R10 s12 off in reset", {31'd0, tx_tag_s12_o}, 32'd0);
    wr(8'h08, 32'h0000_0220);
    wr(8'h60, 32'h0400_0000);
    frame();
    chk("R10 s12 back on", {31'd0, tx_tag_s12_o}, 32'd1);
    wr(8'h60, 32'h0);
    frame();
    chk("R10 s12 disabled", {31'd0, tx_tag_s12_o}, 32'd0);
  endtask

  task automatic t_irq();
    wr(8'h50, 32'hFFFF_FFFF);
    rdchk("R11 tien mask", 8'h50, 32'hC000_0000);
    wr(8'h58, 32'hFFFF_FFFF);
    rdchk("R11 rien mask", 8'h58, 32'h0060_0000);
    chk("R11 idle irq", {31'd0, irq_o}, 32'd0);
    wr(8'h20, 32'h000A_0000);
    frame();
    chk("R11 tx irq", {31'd0, irq_o}, 32'd1);
    wr(8'h50, 32'h0);
    chk("R11 masked", {31'd0, irq_o}, 32'd0);
    wr(8'h54, 32'h0);
    rx(1'b1, 1'b0, 7'h02, 16'h0);
    chk("R11 rx irq", {31'd0, irq_o}, 32'd1);
    wr(8'h5C, 32'h0);
    chk("R11 cleared", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_unmapped();
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk("R12 pcm left", 8'h28, 32'h0);
    rdchk("R12 pcm right", 8'h2C, 32'h0);
    rdchk("R12 offset 0", 8'h00, 32'h0);
    rdchk("R12 ctrl intact", 8'h08, 32'h0000_8220);
    frame();
    chk_tx("R12 no command", 1'b0, 1'b0, 20'h0, 20'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    frame_i = 1'b0; codec_rdy_i = 1'b0; rx_frame_i = 1'b0;
    rx_adr_vld_i = 1'b0; rx_dat_vld_i = 1'b0; rx_sts_idx_i = '0; rx_sts_val_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_write_cmd();
    t_read_cmd();
    t_hold();
    t_rx();
    t_actl();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule